// File: doc/BRIEF.md
# NAND Flash Bus Timing Controller

This block sits between a host register port and a raw NAND flash device. The host writes a command byte, an address byte or data, and each write becomes one or more NAND byte cycles on the CLE, ALE, nWE and IO lines. A host read of the data register becomes read strobe cycles on nRE, and the sampled bytes come back as a single response. Each byte cycle has three programmable parts: a setup time while the latch-enable lines are already valid, a strobe time while nWE or nRE is low, and a hold time after the strobe rises. All three are counted in controller clocks.

Software drives the active-low chip enable through a control bit. It reads the device ready/busy line through a status bit, and it can restart an external ECC accumulator through a self-clearing control bit. While a bus transfer is in progress the host port is not ready. Timing changes therefore only take effect between transfers.

Register select codes: 0 control, 1 timing, 2 command, 3 address, 4 data, 5 status. Control bits: bit 0 controller enable, bit 1 chip deselect (1 drives the chip enable pin high), bit 4 ECC restart. Timing fields hold each phase length minus one: setup in bits [2:0], strobe in bits [10:8], hold in bits [18:16]. Setup is limited to 2 bits unless the parameter `WIDE_SETUP` is set.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, nand_ce_no, nand_we_no and nand_re_no are 1, and nand_cle_o and nand_ale_o are 0. The control register reads 0x2 (disabled, deselected). The timing register reads 0x00070703: setup 4, strobe 8 and hold 8 clocks with the 2-bit setup field.
- R2: A byte cycle spends setup+1 clocks with the strobe high, then strobe+1 clocks with the strobe low, then hold+1 clocks with the strobe high. req_ready_o stays 0 for exactly the sum of the three.
- R3: A write to the command register (select 2) makes one byte cycle with nand_cle_o high, nand_ale_o low, and wdata[7:0] on nand_io_o while nWE is low.
- R4: A write to the address register (select 3) makes one byte cycle with nand_ale_o high, nand_cle_o low, and wdata[7:0] on nand_io_o.
- R5: A word write (req_size_i=1) to the data register makes four back-to-back byte cycles, least significant byte first. A byte write (req_size_i=0) makes one cycle carrying wdata[7:0].
- R6: A data-register read makes four nRE strobes for a word, or one for a byte. rsp_valid_o pulses once when req_ready_o returns high. rsp_rdata_o holds the bytes sampled at the end of each strobe, least significant first, with a byte read zero-extended.
- R7: nand_ce_no equals the deselect bit OR'ed with the inverse of the enable bit. A control write that raises the enable bit from 0 to 1 forces the deselect bit to 1, whatever value was written.
- R8: With the controller disabled, command, address and data requests make no strobes, and a data read responds with 0.
- R9: Status (select 5) bit 0 reads the R/B input (1 ready, 0 busy) after a two-flop synchronizer.
- R10: A control write with bit 4 set pulses ecc_restart_o for one clock. Bit 4 always reads back 0.
- R11: A timing write is read back with its fields, and the setup field is masked to its width. The new timing governs the next byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Host request accepted when high with valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_sel_i | input | 3 | Register select |
| req_size_i | input | 1 | Data register access size: 0 byte, 1 word |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid, one clock |
| rsp_rdata_o | output | 32 | Read response data |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_io_o | output | 8 | IO bus output value |
| nand_io_oe_o | output | 1 | IO bus output enable |
| nand_io_i | input | 8 | IO bus input value |
| nand_rb_i | input | 1 | Device ready (1) / busy (0) |
| ecc_restart_o | output | 1 | ECC accumulator restart pulse |

## Verification
The assertions take for granted that the host never writes the ECC restart bit in two consecutive clocks. They also assume that the host changes the control register only while the port is ready, which the handshake itself enforces. The bench presents each request once, waits for ready between requests, and separates control writes with at least one idle clock. The device read data changes only after a rising nRE edge, so the byte the block samples at the end of each strobe is known in advance. A sweep over every setup, strobe and hold setting of the narrow configuration checks each phase length.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;
  localparam int unsigned PH_W   = 3;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / BUS_W;
  localparam int unsigned IDX_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_TIMING = 3'd1,
    REG_CMD    = 3'd2,
    REG_ADDR   = 3'd3,
    REG_DATA   = 3'd4,
    REG_STATUS = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CYC_CMD   = 2'd0,
    CYC_ADDR  = 2'd1,
    CYC_WDATA = 2'd2,
    CYC_RDATA = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    logic [PH_W-1:0] setup;
    logic [PH_W-1:0] strobe;
    logic [PH_W-1:0] hold;
  } timing_t;
endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_bus_pkg::*;
#(
  parameter bit WIDE_SETUP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rb_i,
  output logic              en_o,
  output logic              nce_o,
  output logic              ecc_init_o,
  output timing_t           timing_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam logic [PH_W-1:0] SETUP_MASK = WIDE_SETUP ? 3'b111 : 3'b011;

  logic       en_q, nce_q, ecc_q;
  timing_t    timing_q;
  logic [1:0] rb_sync_q;
  logic       unused_wdata;

  assign unused_wdata = ^{wdata_i[31:19], wdata_i[15:11], wdata_i[7:5], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q            <= 1'b0;
      nce_q           <= 1'b1;
      ecc_q           <= 1'b0;
      timing_q.setup  <= SETUP_MASK;
      timing_q.strobe <= '1;
      timing_q.hold   <= '1;
      rb_sync_q       <= 2'b00;
    end else begin
      ecc_q     <= 1'b0;
      rb_sync_q <= {rb_sync_q[0], rb_i};
      if (wr_i && sel_i == REG_CTRL) begin
        en_q  <= wdata_i[0];
        // enabling forces the chip deselected
        nce_q <= wdata_i[1] | (wdata_i[0] & ~en_q);
        ecc_q <= wdata_i[4];
      end
      if (wr_i && sel_i == REG_TIMING) begin
        timing_q.setup  <= wdata_i[2:0] & SETUP_MASK;
        timing_q.strobe <= wdata_i[10:8];
        timing_q.hold   <= wdata_i[18:16];
      end
    end
  end

  always_comb begin
    unique case (sel_i)
      REG_CTRL:   rdata_o = {30'b0, nce_q, en_q};
      REG_TIMING: rdata_o = {13'b0, timing_q.hold, 5'b0, timing_q.strobe, 5'b0, timing_q.setup};
      REG_STATUS: rdata_o = {31'b0, rb_sync_q[1]};
      default:    rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign nce_o      = nce_q;
  assign ecc_init_o = ecc_q;
  assign timing_o   = timing_q;
endmodule

// File: rtl/nand_byte_seq.sv
module nand_byte_seq
  import nand_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cyc_kind_e         kind_i,
  input  logic [IDX_W-1:0]  last_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  timing_t           timing_i,
  input  logic [BUS_W-1:0]  io_i,
  output logic              busy_o,
  output logic              rd_done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [BUS_W-1:0]  io_o,
  output logic              io_oe_o
);
  phase_e            phase_q, phase_d;
  cyc_kind_e         kind_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [WORD_W-1:0] wdata_q;
  logic [BUS_W-1:0]  lane_q [LANES];
  logic              fin_q;
  logic              load;
  logic [PH_W-1:0]   load_val;
  logic              done;
  logic              last_end;
  logic              capture;

  nand_phase_timer #(.W(PH_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .done_o (done)
  );

  assign last_end = (phase_q == PH_HOLD) && done && (idx_q == last_q);
  assign capture  = (phase_q == PH_STROBE) && done && (kind_q == CYC_RDATA);

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = timing_i.setup;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_SETUP;
        load    = 1'b1;
      end
      PH_SETUP: if (done) begin
        phase_d  = PH_STROBE;
        load     = 1'b1;
        load_val = timing_i.strobe;
      end
      PH_STROBE: if (done) begin
        phase_d  = PH_HOLD;
        load     = 1'b1;
        load_val = timing_i.hold;
      end
      PH_HOLD: if (done) begin
        phase_d = last_end ? PH_IDLE : PH_SETUP;
        load    = !last_end;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= CYC_CMD;
      idx_q   <= '0;
      last_q  <= '0;
      wdata_q <= '0;
      fin_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fin_q   <= last_end;
      if (phase_q == PH_IDLE && start_i) begin
        kind_q  <= kind_i;
        idx_q   <= '0;
        last_q  <= last_i;
        wdata_q <= wdata_i;
      end else if (phase_q == PH_HOLD && done && !last_end) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  lane_q[g] <= '0;
      else if (phase_q == PH_IDLE && start_i)       lane_q[g] <= '0;
      else if (capture && idx_q == IDX_W'(g))       lane_q[g] <= io_i;
    end
    assign rdata_o[g*BUS_W +: BUS_W] = lane_q[g];
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign rd_done_o = fin_q && (kind_q == CYC_RDATA);
  assign cle_o     = busy_o && (kind_q == CYC_CMD);
  assign ale_o     = busy_o && (kind_q == CYC_ADDR);
  assign we_no     = !((phase_q == PH_STROBE) && (kind_q != CYC_RDATA));
  assign re_no     = !((phase_q == PH_STROBE) && (kind_q == CYC_RDATA));
  assign io_o      = wdata_q[idx_q*BUS_W +: BUS_W];
  assign io_oe_o   = busy_o && (kind_q != CYC_RDATA);
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nand_bus_pkg::*;
#(
  parameter bit WIDE_SETUP = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [2:0]  req_sel_i,
  input  logic        req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_we_no,
  output logic        nand_re_no,
  output logic        nand_ce_no,
  output logic [7:0]  nand_io_o,
  output logic        nand_io_oe_o,
  input  logic [7:0]  nand_io_i,
  input  logic        nand_rb_i,
  output logic        ecc_restart_o
);
  reg_sel_e          sel;
  logic              accept, bus_req, busy;
  logic              en_w, nce_w, rd_done;
  timing_t           timing_w;
  logic [WORD_W-1:0] reg_rdata, seq_rdata;
  cyc_kind_e         kind;
  logic [IDX_W-1:0]  last;
  logic              rsp_q;
  logic [WORD_W-1:0] rsp_data_q;

  assign sel         = reg_sel_e'(req_sel_i);
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;
  assign bus_req     = accept && en_w &&
                       ((req_write_i && (sel == REG_CMD || sel == REG_ADDR)) || sel == REG_DATA);

  always_comb begin
    unique case (sel)
      REG_CMD:  kind = CYC_CMD;
      REG_ADDR: kind = CYC_ADDR;
      default:  kind = req_write_i ? CYC_WDATA : CYC_RDATA;
    endcase
  end

  assign last = (sel == REG_DATA && req_size_i) ? IDX_W'(LANES - 1) : '0;

  nand_host_regs #(.WIDE_SETUP(WIDE_SETUP)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (accept && req_write_i),
    .sel_i      (sel),
    .wdata_i    (req_wdata_i),
    .rb_i       (nand_rb_i),
    .en_o       (en_w),
    .nce_o      (nce_w),
    .ecc_init_o (ecc_restart_o),
    .timing_o   (timing_w),
    .rdata_o    (reg_rdata)
  );

  nand_byte_seq i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (bus_req),
    .kind_i    (kind),
    .last_i    (last),
    .wdata_i   (req_wdata_i),
    .timing_i  (timing_w),
    .io_i      (nand_io_i),
    .busy_o    (busy),
    .rd_done_o (rd_done),
    .rdata_o   (seq_rdata),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_no     (nand_we_no),
    .re_no     (nand_re_no),
    .io_o      (nand_io_o),
    .io_oe_o   (nand_io_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q      <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      rsp_q <= accept && !req_write_i && !bus_req;
      if (accept && !req_write_i && !bus_req) rsp_data_q <= reg_rdata;
    end
  end

  assign rsp_valid_o = rsp_q || rd_done;
  assign rsp_rdata_o = rd_done ? seq_rdata : rsp_data_q;
  assign nand_ce_no  = nce_w || !en_w;
endmodule

// File: rtl/nand_bus_ctrl_chk.sv
module nand_bus_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_ni,
  input logic       re_ni,
  input logic [7:0] io_i,
  input logic       ecc_i,
  input logic       en_i,
  input logic [8:0] timing_i
);
  p_cle_ale_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_i && ale_i));

  p_idle_no_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (we_ni && re_ni));

  p_off_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (ready_i && we_ni && re_ni));

  p_timing_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> $stable(timing_i));

  p_ecc_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_i |=> !ecc_i);

  p_io_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> $stable(io_i));
endmodule

bind nand_bus_ctrl nand_bus_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_i  (req_ready_o),
  .cle_i    (nand_cle_o),
  .ale_i    (nand_ale_o),
  .we_ni    (nand_we_no),
  .re_ni    (nand_re_no),
  .io_i     (nand_io_o),
  .ecc_i    (ecc_restart_o),
  .en_i     (en_w),
  .timing_i (timing_w)
);

// File: tb/test_nand_bus_ctrl.sv
`timescale 1ns/1ps
module test_nand_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [2:0]  req_sel = 3'd0;
  logic [31:0] req_wdata = '0;
  logic        rb = 1'b0;
  logic        req_ready, rsp_valid, cle, ale, we_n, re_n, ce_n, io_oe, ecc;
  logic [31:0] rsp_rdata;
  logic [7:0]  io_o, io_i;
  logic [7:0]  rd_idx = 8'd0;

  int n_chk = 0, n_fail = 0;
  int we_total = 0, re_total = 0, ecc_total = 0, rsp_cnt = 0;
  logic [31:0] rsp_last = '0;
  bit   log_on = 1'b0;
  int   n = 0;
  bit   l_we [512];
  bit   l_re [512];
  bit   l_cle [512];
  bit   l_ale [512];
  logic [7:0] l_io [512];

  always #2.5 clk = ~clk;

  assign io_i = 8'hA0 + rd_idx;
  always @(posedge re_n) rd_idx <= rd_idx + 8'd1;

  nand_bus_ctrl i_nand_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_sel_i(req_sel), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_ce_no(ce_n), .nand_io_o(io_o), .nand_io_oe_o(io_oe), .nand_io_i(io_i),
    .nand_rb_i(rb), .ecc_restart_o(ecc)
  );

  always @(negedge clk) begin
    if (!we_n) we_total++;
    if (!re_n) re_total++;
    if (ecc) ecc_total++;
    if (rsp_valid) begin rsp_cnt++; rsp_last = rsp_rdata; end
    if (log_on && !req_ready && n < 512) begin
      l_we[n] = !we_n; l_re[n] = !re_n; l_cle[n] = cle; l_ale[n] = ale; l_io[n] = io_o;
      n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic access(input bit w, input logic [2:0] sel, input bit size, input logic [31:0] data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n = 0;
    req_valid = 1'b1; req_write = w; req_sel = sel; req_size = size; req_wdata = data;
    @(posedge clk);
    log_on = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    log_on = 1'b0;
  endtask

  function automatic int count_we();
    int c = 0;
    for (int i = 0; i < n; i++) if (l_we[i]) c++;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base, rs, c;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the pins
    chk(req_ready && ce_n && we_n && re_n && !cle && !ale, "R1 pins",
        {26'b0, req_ready, ce_n, we_n, re_n, cle, ale}, 32'h3C);
    access(1'b0, 3'd0, 1'b0, '0);
    chk(rsp_last == 32'h2, "R1 ctrl", rsp_last, 32'h2);
    access(1'b0, 3'd1, 1'b0, '0);
    chk(rsp_last == 32'h00070703, "R1 timing", rsp_last, 32'h00070703);

    // R8 disabled: no strobes, data read returns 0
    base = we_total;
    access(1'b1, 3'd2, 1'b0, 32'h5A);
    chk(we_total == base && n == 0, "R8 cmd ignored", we_total - base, 0);
    rs = rsp_cnt;
    access(1'b0, 3'd4, 1'b1, '0);
    chk(rsp_cnt == rs + 1 && rsp_last == 0 && re_total == 0, "R8 read zero", rsp_last, 0);

    // R7 enable rising forces deselect
    access(1'b1, 3'd0, 1'b0, 32'h1);
    access(1'b0, 3'd0, 1'b0, '0);
    chk(rsp_last == 32'h3 && ce_n, "R7 enable deselects", rsp_last, 32'h3);
    access(1'b1, 3'd0, 1'b0, 32'h1);
    chk(!ce_n, "R7 select", ce_n, 0);
    access(1'b1, 3'd0, 1'b0, 32'h3);
    chk(ce_n, "R7 deselect", ce_n, 1);
    access(1'b1, 3'd0, 1'b0, 32'h1);
    access(1'b1, 3'd0, 1'b0, 32'h0);
    chk(ce_n, "R7 disabled high", ce_n, 1);
    access(1'b1, 3'd0, 1'b0, 32'h1);
    access(1'b1, 3'd0, 1'b0, 32'h1);
    chk(!ce_n, "R7 reselect", ce_n, 0);

    // R10 ECC restart pulse
    base = ecc_total;
    access(1'b1, 3'd0, 1'b0, 32'h11);
    access(1'b0, 3'd0, 1'b0, '0);
    chk(ecc_total == base + 1, "R10 pulse count", ecc_total - base, 1);
    chk(rsp_last == 32'h1, "R10 bit reads 0", rsp_last, 32'h1);

    // R9 status follows R/B
    rb = 1'b0; repeat (4) @(negedge clk);
    access(1'b0, 3'd5, 1'b0, '0);
    chk(rsp_last == 0, "R9 busy", rsp_last, 0);
    rb = 1'b1; repeat (4) @(negedge clk);
    access(1'b0, 3'd5, 1'b0, '0);
    chk(rsp_last == 1, "R9 ready", rsp_last, 1);

    // R11 timing readback with setup masked
    access(1'b1, 3'd1, 1'b0, 32'hFFFF_FFFF);
    access(1'b0, 3'd1, 1'b0, '0);
    chk(rsp_last == 32'h00070703, "R11 readback", rsp_last, 32'h00070703);

    // R2/R3/R11 sweep of all phase settings
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 8; p++)
        for (int h = 0; h < 8; h++) begin
          logic [7:0] b;
          int fw;
          b = 8'(s * 64 + p * 8 + h);
          access(1'b1, 3'd1, 1'b0, (h << 16) | (p << 8) | s);
          access(1'b1, 3'd2, 1'b0, {24'h0, b});
          chk(n == s + p + h + 3, "R2 busy length", n, s + p + h + 3);
          fw = -1;
          for (int i = n - 1; i >= 0; i--) if (l_we[i]) fw = i;
          chk(count_we() == p + 1 && fw == s + 1, "R2 strobe window", {fw[15:0], 16'(count_we())},
              {16'(s + 1), 16'(p + 1)});
          ok = 1'b1;
          for (int i = 0; i < n; i++) if (!l_cle[i] || l_ale[i]) ok = 1'b0;
          chk(ok && fw >= 0 && l_io[s + 1] == b, "R3 cmd cycle", l_io[s + 1], b);
        end

    // setup 2, strobe 3, hold 2: 7 clocks per byte
    access(1'b1, 3'd1, 1'b0, 32'h0001_0201);
    access(1'b1, 3'd3, 1'b0, 32'h0000_0077);
    ok = (n == 7) && l_io[2] == 8'h77 && count_we() == 3;
    for (int i = 0; i < n; i++) if (!l_ale[i] || l_cle[i]) ok = 1'b0;
    chk(ok, "R4 addr cycle", l_io[2], 8'h77);

    access(1'b1, 3'd4, 1'b1, 32'hDDCC_BBAA);
    chk(n == 28 && count_we() == 12, "R5 word length", n, 28);
    for (int k = 0; k < 4; k++)
      chk(l_we[k * 7 + 2] && l_io[k * 7 + 2] == 8'(32'hDDCC_BBAA >> (8 * k)), "R5 byte order",
          l_io[k * 7 + 2], 8'(32'hDDCC_BBAA >> (8 * k)));
    access(1'b1, 3'd4, 1'b0, 32'h1234_5633);
    chk(n == 7 && count_we() == 3 && l_io[2] == 8'h33, "R5 byte write", l_io[2], 8'h33);

    // R6 reads
    base = re_total; rs = rsp_cnt; c = int'(rd_idx);
    access(1'b0, 3'd4, 1'b1, '0);
    begin
      logic [31:0] e;
      for (int k = 0; k < 4; k++) e[8*k +: 8] = 8'hA0 + 8'(c + k);
      chk(rsp_cnt == rs + 1 && rsp_last == e, "R6 word read", rsp_last, e);
    end
    chk(re_total - base == 12 && n == 28, "R6 strobe count", re_total - base, 12);
    rs = rsp_cnt; c = int'(rd_idx);
    access(1'b0, 3'd4, 1'b0, '0);
    chk(rsp_cnt == rs + 1 && rsp_last == {24'h0, 8'hA0 + 8'(c)}, "R6 byte read",
        rsp_last, {24'h0, 8'hA0 + 8'(c)});
    summary();
  end
endmodule